// File: doc/BRIEF.md
# Stack-Language Helper Sequencer

This unit carries out two helper operations of a threaded stack language over a byte-wide memory with a 24-bit address space. It keeps a 32-bit top-of-stack register, a 32-bit second register, a 24-bit thread pointer, a 24-bit stack pointer and a zero flag. A one-cycle start pulse, together with an operation select, launches one operation. The unit then drives the memory port itself, one byte access per cycle, until the operation completes.

The test-and-advance operation reads the 32-bit cell at the thread pointer. It moves the old top value into the second register, places the fetched cell in top-of-stack, steps the thread pointer past the cell and sets the zero flag when the moved value is zero.

The literal operation first pushes the old top value onto the memory stack. It then loads the four bytes found at the instruction pointer into top-of-stack. The instruction pointer is sampled at start and returned advanced past the literal.

Memory read data is combinational: it answers the address driven in the same cycle. All 32-bit values are stored little-endian, with the least significant byte at the lowest address.

Top module: `stack_helper_seq`

## Requirements
- R1: After reset, top-of-stack, the second register, the zero flag, busy, done and the advanced instruction pointer are 0. The thread pointer equals parameter TP_RESET and the stack pointer equals SP_RESET.
- R2: When a test-and-advance operation completes (op_sel = 0), the second register holds the top-of-stack value from before the operation.
- R3: When a test-and-advance operation completes, top-of-stack holds the little-endian word at the old thread pointer. The addresses of its bytes wrap modulo 2^24.
- R4: A test-and-advance operation leaves the thread pointer 4 higher, modulo 2^24.
- R5: A test-and-advance operation sets the zero flag exactly when the value moved into the second register is zero.
- R6: A literal operation (op_sel = 1) lowers the stack pointer by 4, modulo 2^24. It writes the old top-of-stack value little-endian at the lowered pointer.
- R7: A literal operation loads top-of-stack with the little-endian word at the instruction pointer sampled at start. It returns that pointer plus 4 on ip_next_o.
- R8: A literal operation leaves the second register, the thread pointer and the zero flag unchanged. A test-and-advance operation leaves the stack pointer unchanged.
- R9: done is a single-cycle pulse. For test-and-advance it appears 5 cycles after the cycle in which start is presented; for a literal it appears after 9 cycles. busy is high in between.
- R10: A start presented while busy is ignored. The running operation keeps its timing and its results.
- R11: The memory port never reads and writes in the same cycle, and it makes no access while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op_sel | input | 1 | 0 = test-and-advance, 1 = literal |
| ip_i | input | 24 | Instruction pointer, sampled with start |
| ip_next_o | output | 24 | Instruction pointer past the last literal |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tos_o | output | 32 | Top-of-stack register |
| nos_o | output | 32 | Second register |
| tp_o | output | 24 | Thread pointer |
| sp_o | output | 24 | Stack pointer |
| zero_o | output | 1 | Zero flag |
| mem_addr_o | output | 24 | Byte address |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte for the address driven in the same cycle |

## Verification
The bench builds the unit with TP_RESET = 24'hFFFFFA and SP_RESET = 24'h000802, keeping the default 24-bit address and 32-bit data widths. With this thread pointer, the second fetch straddles the top of the address space, reading bytes FFFFFE, FFFFFF, 000000 and 000001. That brings wrap of both the pointer and a word's byte addresses within reach in the first few operations. A directed literal at instruction pointer FFFFFE covers the same wrap on the literal path. A thread cell of zero and a zero top value at reset exercise both settings of the zero flag.

// File: rtl/stack_helper_pkg.sv
// Package stack_helper_pkg
// Shared operation and sequencer state encodings for the stack helper unit.
// Assumes a single select bit distinguishes the two operations.
package stack_helper_pkg;

    typedef enum logic {
        OP_TEST = 1'b0,
        OP_LIT  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH  = 2'd1,
        ST_FETCH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/stack_helper_ctrl.sv
// Module stack_helper_ctrl
// Phase sequencer: accepts a start while idle, runs an optional four-byte
// push phase (literal only), then a four-byte fetch phase, and flags the last
// fetch cycle plus a registered done pulse. Assumes start is ignored when busy.
module stack_helper_ctrl
    import stack_helper_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_sel,
    output logic             accept,
    output logic             busy,
    output logic             in_push,
    output logic             in_fetch,
    output logic             last,
    output logic             done,
    output op_e              op_q,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

    seq_state_e state_q;

    assign accept   = (state_q == ST_IDLE) && start;
    assign busy     = (state_q != ST_IDLE);
    assign in_push  = (state_q == ST_PUSH);
    assign in_fetch = (state_q == ST_FETCH);
    assign last     = in_fetch && (idx == IDX_LAST);

    // Advance the phase state and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            op_q    <= OP_TEST;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_e'(op_sel);
                        idx     <= '0;
                        state_q <= op_sel ? ST_PUSH : ST_FETCH;
                    end
                end
                ST_PUSH: begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_LAST) begin
                        idx     <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_LAST) begin
                        idx     <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the completion pulse one edge after the last fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last;
    end

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the captured operation cannot change while an operation runs
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));

endmodule

// File: rtl/stack_helper_collect.sv
// Module stack_helper_collect
// Assembles a little-endian word from bytes arriving lowest address first.
// The full word is available combinationally while the final byte is on the
// bus. Assumes one byte per capture strobe.
module stack_helper_collect #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DATA_W-1:0] word_full
);

    logic [DATA_W-1:0] shift_q;

    assign word_full = {byte_in, shift_q[DATA_W-1:BYTE_W]};

    // Shift each new byte in from the top so the first byte ends lowest.
    always_ff @(posedge clk) begin
        if (!rst_n)       shift_q <= '0;
        else if (capture) shift_q <= word_full;
    end

endmodule

// File: rtl/stack_helper_port.sv
// Module stack_helper_port
// Memory port driver: forms the byte address from the active base pointer and
// byte index, selects the push byte, and raises exactly one strobe per busy
// cycle. Assumes pointer arithmetic wraps at the address width.
module stack_helper_port
    import stack_helper_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              in_push,
    input  logic              in_fetch,
    input  op_e               op_q,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] tp,
    input  logic [ADDR_W-1:0] ip,
    input  logic [DATA_W-1:0] tos,
    output logic [ADDR_W-1:0] addr,
    output logic              re,
    output logic              we,
    output logic [BYTE_W-1:0] wdata
);

    localparam logic [ADDR_W-1:0] CELL = ADDR_W'(NBYTES);

    logic [ADDR_W-1:0] base;
    logic [DATA_W-1:0] shifted;

    // Pick the pointer that addresses the current phase.
    always_comb begin
        if (in_push)              base = sp - CELL;
        else if (op_q == OP_TEST) base = tp;
        else                      base = ip;
    end

    // Byte address, strobes and outgoing byte.
    always_comb begin
        addr    = base + ADDR_W'(idx);
        re      = in_fetch;
        we      = in_push;
        shifted = tos >> (BYTE_W * int'(idx));
        wdata   = shifted[BYTE_W-1:0];
    end

endmodule

// File: rtl/stack_helper_seq.sv
// Module stack_helper_seq (top)
// Stack-language helper unit: holds the top, second, thread pointer, stack
// pointer and zero flag, and runs test-and-advance or literal over a byte-wide
// memory with combinational read data. Assumes DATA_W is a whole number of bytes.
module stack_helper_seq
    import stack_helper_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter logic [ADDR_W-1:0] TP_RESET = '0,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sel,
    input  logic [ADDR_W-1:0] ip_i,
    output logic [ADDR_W-1:0] ip_next_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] tos_o,
    output logic [DATA_W-1:0] nos_o,
    output logic [ADDR_W-1:0] tp_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              zero_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [ADDR_W-1:0] CELL = ADDR_W'(NBYTES);

    logic              accept, busy, in_push, in_fetch, last, done;
    op_e               op_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word_full;
    logic [DATA_W-1:0] tos_q, nos_q;
    logic [ADDR_W-1:0] tp_q, sp_q, ip_q, ip_next_q;
    logic              zero_q;

    stack_helper_ctrl #(.NBYTES(NBYTES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .accept(accept), .busy(busy), .in_push(in_push), .in_fetch(in_fetch),
        .last(last), .done(done), .op_q(op_q), .idx(idx)
    );

    stack_helper_collect #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) collect_i (
        .clk(clk), .rst_n(rst_n), .capture(in_fetch),
        .byte_in(mem_rdata_i), .word_full(word_full)
    );

    stack_helper_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) port_i (
        .in_push(in_push), .in_fetch(in_fetch), .op_q(op_q), .idx(idx),
        .sp(sp_q), .tp(tp_q), .ip(ip_q), .tos(tos_q),
        .addr(mem_addr_o), .re(mem_re_o), .we(mem_we_o), .wdata(mem_wdata_o)
    );

    // Sample the instruction pointer when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      ip_q <= '0;
        else if (accept) ip_q <= ip_i;
    end

    // Commit the architectural registers in the last fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q     <= '0;
            nos_q     <= '0;
            tp_q      <= TP_RESET;
            sp_q      <= SP_RESET;
            zero_q    <= 1'b0;
            ip_next_q <= '0;
        end else if (last) begin
            tos_q <= word_full;
            if (op_q == OP_TEST) begin
                nos_q  <= tos_q;
                tp_q   <= tp_q + CELL;
                zero_q <= (tos_q == '0);
            end else begin
                sp_q      <= sp_q - CELL;
                ip_next_q <= ip_q + CELL;
            end
        end
    end

    assign busy_o    = busy;
    assign done_o    = done;
    assign tos_o     = tos_q;
    assign nos_o     = nos_q;
    assign tp_o      = tp_q;
    assign sp_o      = sp_q;
    assign zero_o    = zero_q;
    assign ip_next_o = ip_next_q;

    // R11: a single access per cycle
    p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re_o && mem_we_o));

    // R11: no access while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_re_o && !mem_we_o));

    // R4: the thread pointer steps one cell per test-and-advance
    p_tp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_TEST) |-> (tp_o == $past(tp_o) + CELL));

    // R5: zero tracks the moved value
    p_zero_moved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_TEST) |-> (zero_o == (nos_o == '0)));

    // R6: the literal push pre-decrements the stack pointer
    p_sp_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_LIT) |-> (sp_o == $past(sp_o) - CELL));

    // R8: test-and-advance never moves the stack pointer
    p_sp_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_q == OP_TEST) |=> $stable(sp_o));

endmodule

// File: tb/stack_helper_seq_tb_top.sv
// Bench for stack_helper_seq: byte memory model with combinational read, and a
// reference model of the five registers updated from the requirements.
module stack_helper_seq_tb_top;

    localparam logic [23:0] TP0 = 24'hFFFFFA;
    localparam logic [23:0] SP0 = 24'h000802;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sel = 1'b0;
    logic [23:0] ip_i = '0;
    logic [23:0] ip_next_o, tp_o, sp_o, mem_addr_o;
    logic        busy_o, done_o, zero_o, mem_re_o, mem_we_o;
    logic [31:0] tos_o, nos_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;

    logic [7:0] mem [4096];

    int checks = 0;
    int fails  = 0;

    // Reference state.
    logic [31:0] m_tos, m_nos;
    logic [23:0] m_tp, m_sp;
    logic        m_zero;

    always #2 clk = ~clk;

    stack_helper_seq #(.TP_RESET(TP0), .SP_RESET(SP0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .ip_i(ip_i),
        .ip_next_o(ip_next_o), .busy_o(busy_o), .done_o(done_o),
        .tos_o(tos_o), .nos_o(nos_o), .tp_o(tp_o), .sp_o(sp_o), .zero_o(zero_o),
        .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    assign mem_rdata_i = mem[mem_addr_o[11:0]];

    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;

    function automatic logic [31:0] rd_word(input logic [23:0] a);
        logic [23:0] a1 = a + 24'd1;
        logic [23:0] a2 = a + 24'd2;
        logic [23:0] a3 = a + 24'd3;
        return {mem[a3[11:0]], mem[a2[11:0]], mem[a1[11:0]], mem[a[11:0]]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // R11: port discipline monitor, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_re_o && mem_we_o) || (!busy_o && (mem_re_o || mem_we_o))) begin
                checks++;
                fails++;
                $display("FAIL R11 actual re=%b we=%b busy=%b expected one access only when busy",
                         mem_re_o, mem_we_o, busy_o);
            end
        end
    end

    // Run one operation; optionally pulse a stray start while busy (R10).
    task automatic run_op(input logic op, input logic [23:0] ip, input bit stray);
        logic [31:0] exp_word;
        logic [23:0] push_at;
        int lat, want;
        exp_word = op ? rd_word(ip) : rd_word(m_tp);
        push_at  = m_sp - 24'd4;
        want     = op ? 9 : 5;
        lat      = 0;
        start  = 1'b1;
        op_sel = op;
        ip_i   = ip;
        @(negedge clk);
        start = 1'b0;
        ip_i  = ~ip;
        lat   = 1;
        while (!done_o && lat < 20) begin
            check("R9 busy", {31'd0, busy_o}, 32'd1);
            if (stray && lat == 2) begin
                start  = 1'b1;
                op_sel = ~op;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(stray ? "R10 latency" : "R9 latency", lat, want);
        if (op == 1'b0) begin
            m_nos  = m_tos;
            m_zero = (m_tos == 32'd0);
            m_tos  = exp_word;
            m_tp   = m_tp + 24'd4;
            check("R2 nos", nos_o, m_nos);
            check("R3 tos", tos_o, m_tos);
            check("R4 tp", {8'd0, tp_o}, {8'd0, m_tp});
            check("R5 zero", {31'd0, zero_o}, {31'd0, m_zero});
            check("R8 sp", {8'd0, sp_o}, {8'd0, m_sp});
        end else begin
            check("R6 pushed", rd_word(push_at), m_tos);
            m_sp  = push_at;
            m_tos = exp_word;
            check("R6 sp", {8'd0, sp_o}, {8'd0, m_sp});
            check("R7 tos", tos_o, m_tos);
            check("R7 ip_next", {8'd0, ip_next_o}, {8'd0, ip + 24'd4});
            check("R8 nos", nos_o, m_nos);
            check("R8 tp", {8'd0, tp_o}, {8'd0, m_tp});
            check("R8 zero", {31'd0, zero_o}, {31'd0, m_zero});
        end
        @(negedge clk);
        check("R9 pulse", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL R9 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        // Second thread cell (FFFFFE..000001) set to zero for the R5 case.
        mem[12'hFFE] = 8'h00; mem[12'hFFF] = 8'h00;
        mem[12'h000] = 8'h00; mem[12'h001] = 8'h00;
        m_tos = '0; m_nos = '0; m_tp = TP0; m_sp = SP0; m_zero = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 tos", tos_o, 32'd0);
        check("R1 nos", nos_o, 32'd0);
        check("R1 tp", {8'd0, tp_o}, {8'd0, TP0});
        check("R1 sp", {8'd0, sp_o}, {8'd0, SP0});
        check("R1 zero", {31'd0, zero_o}, 32'd0);
        check("R1 busy", {30'd0, busy_o, done_o}, 32'd0);
        check("R1 ip_next", {8'd0, ip_next_o}, 32'd0);
        // Directed corners: zero top at reset, wrapped fetch, zero cell, wrapped literal.
        run_op(1'b0, 24'h0, 1'b0);
        run_op(1'b0, 24'h0, 1'b0);
        run_op(1'b0, 24'h0, 1'b0);
        run_op(1'b1, 24'hFFFFFE, 1'b0);
        run_op(1'b1, 24'h000A40, 1'b1);
        run_op(1'b0, 24'h0, 1'b1);
        // Constrained random mix; literals draw from A00..EFF.
        for (int n = 0; n < 80; n++) begin
            logic op;
            logic [23:0] ip;
            op = 1'($urandom);
            ip = 24'h000A00 + 24'($urandom % 32'h500);
            run_op(op, ip, ($urandom % 5) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule